// File: doc/BRIEF.md
# Readback Data Integrity Checker

This block confirms that packets already written to a remote memory arrived intact. A traffic generator leaves one descriptor per written packet in a show-ahead FIFO. Each descriptor holds the packet identifier, the start address and the length in data words. The checker takes one descriptor whenever the FIFO has one and it is free. It then issues one read burst over a memory-mapped read-master port and compares each returned word with the pattern the generator wrote. That pattern starts with the identifier and increments by one on each following word.

Every burst yields a verdict of good or bad, and the verdict goes into one of two counters. A control port lets software set how many packets make up a run, read both counters and a done flag, and read the identifier of the first failing packet. A clear command resets the counters, the done flag and the first-failure capture, so a new run can start. Only one read burst is in flight at a time. Once the run has reached its programmed packet count, the checker leaves any further descriptors in the FIFO.

Top module: `readback_checker`

## Requirements
- R1: The checker pops the FIFO (`descPop` high for one cycle) only when `descEmpty` is low, no burst is in progress and the done flag is clear. It captures the identifier, address and length presented on that cycle.
- R2: Each popped descriptor produces exactly one read request, starting the cycle after the pop. `rdAddr` equals the descriptor address and `rdBeats` equals its length. The request and its fields stay constant until `rdAccept` is seen high.
- R3: Only one burst is outstanding at a time. No new descriptor is popped, and no new request is raised, until the last of the `rdBeats` data beats has returned.
- R4: Beat k of a burst (k = 0 for the first beat) must equal the identifier plus k, modulo 2^DATA_W. A packet is good only if every beat matches.
- R5: A packet with any mismatching beat adds exactly one to the bad counter, however many of its beats differ.
- R6: Control-port reads are combinational on `ctrlAddr`. Address 1 returns the good count, address 2 returns the bad count, and address 0 returns the packet target.
- R7: Writing address 0 sets the packet target. Its reset value is 1,000,000.
- R8: The done flag is bit 0 of address 3. It is set when good plus bad reaches the target. While it is set, no descriptor is popped.
- R9: Writing address 3 with bit 0 set clears both counters, the done flag and the first-failure capture. It leaves the target unchanged. If the clear coincides with a packet verdict, the clear wins.
- R10: Address 4 returns the identifier of the first bad packet since the last clear. Bit 1 of address 3 shows that one has been captured. Later failures do not overwrite it.
- R11: `rdValid` beats that arrive while no burst is in its data phase are ignored and leave the counters unchanged.
- R12: After reset the counters, the flags and the first-failure register read zero, the target reads 1,000,000, and neither `descPop` nor `rdReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descEmpty | input | 1 | Descriptor FIFO is empty |
| descPop | output | 1 | Pops the head descriptor |
| descId | input | DATA_W | Head descriptor packet identifier |
| descAddr | input | ADDR_W | Head descriptor start address |
| descLen | input | LEN_W | Head descriptor length in beats (1 or more) |
| rdReq | output | 1 | Read burst request |
| rdAddr | output | ADDR_W | Burst start address |
| rdBeats | output | LEN_W | Burst length in beats |
| rdAccept | input | 1 | Memory accepts the request this cycle |
| rdValid | input | 1 | Read data beat valid |
| rdData | input | DATA_W | Read data beat |
| ctrlAddr | input | 3 | Control register select |
| ctrlWrite | input | 1 | Control write strobe |
| ctrlWdata | input | DATA_W | Control write data |
| ctrlRdata | output | DATA_W | Control read data |

## Verification
The hardest situation to reach from the ports is a run that finishes while more descriptors are still waiting. A correct design must then stop popping, and must resume cleanly only after a clear. The bench queues more descriptors than the programmed target and confirms that the surplus stays in the FIFO. It then clears and lowers the target, and watches the checker drain exactly the surplus. Corruption is placed directly on beat 0, on the last beat and on several beats of one packet. A long random run adds random accept and data gaps, an identifier that wraps past the top of the data range, and stray `rdValid` pulses between bursts.

// File: rtl/readback_checker_pkg.sv
package readback_checker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA
  } chkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDesc;
    logic takeBeat;
    logic clearAll;
    logic writeTarget;
  } chkStrobe_t;

  localparam logic [2:0] REG_TARGET   = 3'd0;
  localparam logic [2:0] REG_GOOD     = 3'd1;
  localparam logic [2:0] REG_BAD      = 3'd2;
  localparam logic [2:0] REG_STATUS   = 3'd3;
  localparam logic [2:0] REG_FIRSTBAD = 3'd4;

endpackage

// File: rtl/readback_checker_ctrl.sv
module readback_checker_ctrl
  import readback_checker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descEmpty,
  input  logic       runDone,
  input  logic       lastBeat,
  input  logic       rdAccept,
  input  logic       rdValid,
  input  logic [2:0] ctrlAddr,
  input  logic       ctrlWrite,
  input  logic       clearBit,
  output logic       descPop,
  output logic       rdReq,
  output chkStrobe_t strobe
);

  chkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    descPop   = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (!descEmpty && !runDone) begin
          descPop         = 1'b1;
          strobe.loadDesc = 1'b1;
          stateNext       = ST_REQ;
        end
      end
      ST_REQ: begin
        if (rdAccept) stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (rdValid) begin
          strobe.takeBeat = 1'b1;
          if (lastBeat) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    strobe.clearAll    = ctrlWrite && (ctrlAddr == REG_STATUS) && clearBit;
    strobe.writeTarget = ctrlWrite && (ctrlAddr == REG_TARGET);
  end

  assign rdReq = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/readback_checker_datapath.sv
module readback_checker_datapath
  import readback_checker_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 8,
  parameter int CNT_W          = 32,
  parameter int TARGET_DEFAULT = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  chkStrobe_t        strobe,
  input  logic [DATA_W-1:0] descId,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  input  logic [DATA_W-1:0] rdData,
  input  logic [2:0]        ctrlAddr,
  input  logic [DATA_W-1:0] ctrlWdata,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LEN_W-1:0]  rdBeats,
  output logic              lastBeat,
  output logic              runDone,
  output logic [DATA_W-1:0] ctrlRdata
);

  localparam logic [CNT_W-1:0] TARGET_RST = CNT_W'(TARGET_DEFAULT);

  logic [DATA_W-1:0] curId;
  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W-1:0]  curLen;
  logic [LEN_W-1:0]  beatIdx;
  logic              pktErr;
  logic [CNT_W-1:0]  goodCnt, badCnt, targetCnt;
  logic              doneFlag, firstBadSeen;
  logic [DATA_W-1:0] firstBadId;

  logic [DATA_W-1:0] expWord;
  logic              beatMiss, pktBad;
  logic [CNT_W-1:0]  checkedNext;

  assign expWord     = curId + DATA_W'(beatIdx);
  assign beatMiss    = (rdData != expWord);
  assign lastBeat    = (beatIdx == curLen - LEN_W'(1));
  assign pktBad      = pktErr || beatMiss;
  assign checkedNext = goodCnt + badCnt + CNT_W'(1);

  // packet capture and beat tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curId   <= '0;
      curAddr <= '0;
      curLen  <= '0;
      beatIdx <= '0;
      pktErr  <= 1'b0;
    end else if (strobe.loadDesc) begin
      curId   <= descId;
      curAddr <= descAddr;
      curLen  <= descLen;
      beatIdx <= '0;
      pktErr  <= 1'b0;
    end else if (strobe.takeBeat && !lastBeat) begin
      beatIdx <= beatIdx + LEN_W'(1);
      pktErr  <= pktBad;
    end
  end

  // verdict counters, done, first failure
  always_ff @(posedge clk) begin
    if (!rstN) begin
      goodCnt      <= '0;
      badCnt       <= '0;
      doneFlag     <= 1'b0;
      firstBadSeen <= 1'b0;
      firstBadId   <= '0;
    end else if (strobe.clearAll) begin
      goodCnt      <= '0;
      badCnt       <= '0;
      doneFlag     <= 1'b0;
      firstBadSeen <= 1'b0;
      firstBadId   <= '0;
    end else if (strobe.takeBeat && lastBeat) begin
      if (pktBad) badCnt  <= badCnt + CNT_W'(1);
      else        goodCnt <= goodCnt + CNT_W'(1);
      if (checkedNext == targetCnt) doneFlag <= 1'b1;
      if (pktBad && !firstBadSeen) begin
        firstBadSeen <= 1'b1;
        firstBadId   <= curId;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                   targetCnt <= TARGET_RST;
    else if (strobe.writeTarget) targetCnt <= CNT_W'(ctrlWdata);
  end

  always_comb begin
    ctrlRdata = '0;
    unique case (ctrlAddr)
      REG_TARGET:   ctrlRdata = DATA_W'(targetCnt);
      REG_GOOD:     ctrlRdata = DATA_W'(goodCnt);
      REG_BAD:      ctrlRdata = DATA_W'(badCnt);
      REG_STATUS: begin
        ctrlRdata[0] = doneFlag;
        ctrlRdata[1] = firstBadSeen;
      end
      REG_FIRSTBAD: ctrlRdata = firstBadId;
      default:      ctrlRdata = '0;
    endcase
  end

  assign rdAddr  = curAddr;
  assign rdBeats = curLen;
  assign runDone = doneFlag;

endmodule

// File: rtl/readback_checker.sv
module readback_checker
  import readback_checker_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 32,
  parameter int LEN_W          = 8,
  parameter int CNT_W          = 32,
  parameter int TARGET_DEFAULT = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descEmpty,
  output logic              descPop,
  input  logic [DATA_W-1:0] descId,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic [LEN_W-1:0]  descLen,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LEN_W-1:0]  rdBeats,
  input  logic              rdAccept,
  input  logic              rdValid,
  input  logic [DATA_W-1:0] rdData,
  input  logic [2:0]        ctrlAddr,
  input  logic              ctrlWrite,
  input  logic [DATA_W-1:0] ctrlWdata,
  output logic [DATA_W-1:0] ctrlRdata
);

  chkStrobe_t strobe;
  logic       lastBeat;
  logic       runDone;

  readback_checker_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .descEmpty (descEmpty),
    .runDone   (runDone),
    .lastBeat  (lastBeat),
    .rdAccept  (rdAccept),
    .rdValid   (rdValid),
    .ctrlAddr  (ctrlAddr),
    .ctrlWrite (ctrlWrite),
    .clearBit  (ctrlWdata[0]),
    .descPop   (descPop),
    .rdReq     (rdReq),
    .strobe    (strobe)
  );

  readback_checker_datapath #(
    .DATA_W         (DATA_W),
    .ADDR_W         (ADDR_W),
    .LEN_W          (LEN_W),
    .CNT_W          (CNT_W),
    .TARGET_DEFAULT (TARGET_DEFAULT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .descId    (descId),
    .descAddr  (descAddr),
    .descLen   (descLen),
    .rdData    (rdData),
    .ctrlAddr  (ctrlAddr),
    .ctrlWdata (ctrlWdata),
    .rdAddr    (rdAddr),
    .rdBeats   (rdBeats),
    .lastBeat  (lastBeat),
    .runDone   (runDone),
    .ctrlRdata (ctrlRdata)
  );

endmodule

// File: rtl/readback_checker_sva.sv
module readback_checker_sva #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              descEmpty,
  input logic              descPop,
  input logic              rdReq,
  input logic              rdAccept,
  input logic              rdValid,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [LEN_W-1:0]  rdBeats
);

  logic [LEN_W-1:0] remBeats;
  logic             burstBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remBeats  <= '0;
      burstBusy <= 1'b0;
    end else begin
      if (rdReq && rdAccept)              remBeats <= rdBeats;
      else if (rdValid && remBeats != '0) remBeats <= remBeats - LEN_W'(1);
      if (descPop)                                 burstBusy <= 1'b1;
      else if (rdValid && remBeats == LEN_W'(1))   burstBusy <= 1'b0;
    end
  end

  // R1
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    descPop |-> !descEmpty);

  // R2
  pop_then_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    descPop |=> rdReq);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAccept) |=> (rdReq && $stable(rdAddr) && $stable(rdBeats)));

  // R3
  single_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    descPop |-> !burstBusy);

  // R3
  no_req_in_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remBeats != '0) |-> !rdReq);

endmodule

bind readback_checker readback_checker_sva #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .descEmpty (descEmpty),
  .descPop   (descPop),
  .rdReq     (rdReq),
  .rdAccept  (rdAccept),
  .rdValid   (rdValid),
  .rdAddr    (rdAddr),
  .rdBeats   (rdBeats)
);

// File: tb/readback_checker_tb.sv
module readback_checker_tb;

  localparam int DW = 32;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int NPKT = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          descEmpty = 1'b1;
  logic          descPop;
  logic [DW-1:0] descId = '0;
  logic [AW-1:0] descAddr = '0;
  logic [LW-1:0] descLen = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic [LW-1:0] rdBeats;
  logic          rdAccept = 1'b0;
  logic          rdValid = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic [2:0]    ctrlAddr = '0;
  logic          ctrlWrite = 1'b0;
  logic [DW-1:0] ctrlWdata = '0;
  logic [DW-1:0] ctrlRdata;

  readback_checker u_dut (
    .clk(clk), .rstN(rstN), .descEmpty(descEmpty), .descPop(descPop),
    .descId(descId), .descAddr(descAddr), .descLen(descLen),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdBeats(rdBeats), .rdAccept(rdAccept),
    .rdValid(rdValid), .rdData(rdData), .ctrlAddr(ctrlAddr),
    .ctrlWrite(ctrlWrite), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata)
  );

  always #10 clk = ~clk;

  // packet table, FIFO and memory model state
  logic [DW-1:0] pktId   [NPKT];
  int            pktLen  [NPKT];
  logic [15:0]   pktMask [NPKT];
  int  head = 0, tail = 0;
  bit  popPend = 0, hsPend = 0, beatPend = 0, spur = 0;
  int  hsIdx = 0, memIdx = 0, memBeat = 0;
  bit  memActive = 0;
  int  totalChecks = 0, badChecks = 0;
  bit  finished = 0;

  function automatic logic [DW-1:0] memWord(int idx, int k);
    logic [DW-1:0] w;
    w = pktId[idx] + DW'(k);
    if (pktMask[idx][k]) w = w ^ 32'h0100_0001;
    return w;
  endfunction

  function automatic bit pktIsBad(int idx);
    return pktMask[idx] != 16'h0;
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    totalChecks++;
    if (act !== exp) begin
      badChecks++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regRead(logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    ctrlAddr = a;
    #2;
    d = ctrlRdata;
  endtask

  task automatic regWrite(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk);
    ctrlAddr  = a;
    ctrlWdata = d;
    ctrlWrite = 1'b1;
    @(negedge clk);
    ctrlWrite = 1'b0;
  endtask

  task automatic waitDone(string req);
    logic [DW-1:0] s;
    s = '0;
    for (int i = 0; i < 20000; i++) begin
      regRead(3'd3, s);
      if (s[0]) break;
    end
    check(req, "done flag", DW'(s[0]), 32'd1);
  endtask

  task automatic setPkt(int idx, logic [DW-1:0] id, int len, logic [15:0] mask);
    pktId[idx]   = id;
    pktLen[idx]  = len;
    pktMask[idx] = mask;
  endtask

  // FIFO and remote memory model: drive at negedge, observe before posedge
  initial begin
    forever begin
      @(negedge clk);
      if (popPend) head++;
      popPend = 0;
      if (hsPend) begin
        memActive = 1; memIdx = hsIdx; memBeat = 0; hsPend = 0;
      end
      if (beatPend) begin
        memBeat++;
        if (memBeat == pktLen[memIdx]) memActive = 0;
        beatPend = 0;
      end
      descEmpty = (head >= tail);
      if (head < NPKT) begin
        descId   = pktId[head];
        descAddr = AW'(head) << 8;
        descLen  = LW'(pktLen[head]);
      end
      rdAccept = ($urandom % 3) != 0;
      if (memActive && ($urandom % 4) != 0) begin
        rdValid = 1'b1;
        rdData  = memWord(memIdx, memBeat);
      end else if (!memActive && spur) begin
        rdValid = 1'b1;
        rdData  = $urandom;
      end else begin
        rdValid = 1'b0;
        rdData  = $urandom;
      end
      #8;
      popPend = descPop;
      if (rdReq && rdAccept) begin
        hsPend = 1;
        hsIdx  = int'(rdAddr >> 8);
        // R2 request carries the descriptor's address and length
        check("R2", "burst address", rdAddr, AW'(hsIdx) << 8);
        check("R2", "burst beats", DW'(rdBeats), DW'(pktLen[hsIdx]));
      end
      beatPend = rdValid && memActive;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      badChecks++;
      totalChecks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    int expGood, expBad, popBase;
    logic [DW-1:0] expFirst;
    bit firstSeen;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPKT; i++) setPkt(i, '0, 1, '0);

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    regRead(3'd0, d); check("R12", "target after reset", d, 32'd1000000);
    regRead(3'd1, d); check("R12", "good after reset", d, 32'd0);
    regRead(3'd2, d); check("R12", "bad after reset", d, 32'd0);
    regRead(3'd3, d); check("R12", "status after reset", d, 32'd0);
    regRead(3'd4, d); check("R12", "first bad after reset", d, 32'd0);
    check("R12", "no pop or request", DW'({descPop, rdReq}), 32'd0);

    // R7 R4 clean run of 8 with length 1 and 16 corners
    regWrite(3'd0, 32'd8);
    regRead(3'd0, d); check("R7", "target written", d, 32'd8);
    setPkt(0, 32'h0000_1000, 1, '0);
    setPkt(1, 32'h0000_2000, 16, '0);
    for (int i = 2; i < 8; i++) setPkt(i, $urandom, 1 + int'($urandom % 16), '0);
    tail = 8;
    waitDone("R8");
    regRead(3'd1, d); check("R4", "good count clean run", d, 32'd8);
    regRead(3'd2, d); check("R6", "bad count clean run", d, 32'd0);
    regRead(3'd3, d); check("R10", "no failure captured", d, 32'd1);
    check("R1", "descriptors popped", DW'(head), 32'd8);

    // R11 stray beats between bursts
    spur = 1;
    repeat (12) @(negedge clk);
    spur = 0;
    repeat (2) @(negedge clk);
    regRead(3'd1, d); check("R11", "good unchanged by stray beats", d, 32'd8);
    regRead(3'd2, d); check("R11", "bad unchanged by stray beats", d, 32'd0);

    // R9 clear
    regWrite(3'd3, 32'd1);
    regRead(3'd1, d); check("R9", "good cleared", d, 32'd0);
    regRead(3'd2, d); check("R9", "bad cleared", d, 32'd0);
    regRead(3'd3, d); check("R9", "status cleared", d, 32'd0);
    regRead(3'd0, d); check("R9", "target kept", d, 32'd8);

    // R5 R10 R8 directed corruption, surplus descriptors
    regWrite(3'd0, 32'd10);
    for (int i = 8; i < 21; i++) setPkt(i, $urandom, 4 + int'($urandom % 8), '0);
    pktMask[9]  = 16'h000F;                       // several beats wrong
    pktMask[11] = 16'h0001;                       // identifier word wrong
    pktMask[14] = 16'h1 << (pktLen[14] - 1);      // last beat wrong
    tail = 21;
    waitDone("R8");
    regRead(3'd1, d); check("R6", "good with errors", d, 32'd7);
    regRead(3'd2, d); check("R5", "bad counted once each", d, 32'd3);
    regRead(3'd4, d); check("R10", "first failing id", d, pktId[9]);
    regRead(3'd3, d); check("R10", "capture flag", d, 32'd3);
    repeat (40) @(negedge clk);
    check("R8", "no pop after done", DW'(head), 32'd18);

    // R9 clear restarts, surplus drains
    regWrite(3'd0, 32'd3);
    regWrite(3'd3, 32'd1);
    waitDone("R8");
    regRead(3'd1, d); check("R9", "good after restart", d, 32'd3);
    regRead(3'd4, d); check("R10", "first bad cleared", d, 32'd0);
    check("R1", "surplus drained", DW'(head), 32'd21);

    // random run with wrap of identifier
    expGood = 0; expBad = 0; firstSeen = 0; expFirst = '0;
    for (int i = 21; i < 171; i++) begin
      int len;
      logic [15:0] m;
      len = 1 + int'($urandom % 16);
      m = (($urandom % 4) == 0) ? (16'($urandom) & 16'((32'h1 << len) - 1)) : 16'h0;
      setPkt(i, $urandom, len, m);
    end
    setPkt(22, 32'hFFFF_FFFD, 8, '0);
    for (int i = 21; i < 171; i++) begin
      if (pktIsBad(i)) begin
        expBad++;
        if (!firstSeen) begin firstSeen = 1; expFirst = pktId[i]; end
      end else expGood++;
    end
    popBase = head;
    regWrite(3'd0, 32'd150);
    regWrite(3'd3, 32'd1);
    tail = 171;
    waitDone("R8");
    regRead(3'd1, d); check("R4", "random good count", d, DW'(expGood));
    regRead(3'd2, d); check("R5", "random bad count", d, DW'(expBad));
    regRead(3'd4, d); check("R10", "random first failure", d, expFirst);
    check("R3", "bursts handled", DW'(head - popBase), 32'd150);

    finished = 1;
    $display("test done: total=%0d bad=%0d", totalChecks, badChecks);
    $finish;
  end

endmodule